// File: doc/BRIEF.md
# Selectable-Ratio Clock Divider Bank

This block sits behind a frequency-multiplying loop and turns its single high-rate source clock into a set of slower clocks. The outputs are a downstream clock, which is driven onto two identical ports, an upstream clock, a fixed system-reference clock and a feedback clock for the loop's phase comparison. Static select pins set each ratio. A one-bit pick routes one of two reference inputs straight through to the comparison point. The feedback path is a cascade of two stages, a coarse stage and a five-way stage. The divider that feeds the system reference takes its setting from the coarse-stage select, so the system reference always runs at source/48.

Each output is a 2-bit half-cycle pair. Bit [1] is the output level during the first (high) half of the current source cycle, and bit [0] is the level during the second half. An odd ratio such as /3 is therefore exactly 50% duty with no falling-edge logic. Every counter restarts together at one common epoch of 240 source cycles, and all ratios divide 240. Select changes are taken in only at that epoch.

Top module: `clkdiv_bank`

## Requirements
- R1: The upstream ratio follows `us_sel`: 0 gives /1, 1 gives /3, 2 gives /6, 3 gives /12. The output period is 2×ratio half-cycles.
- R2: The downstream ratio is /2 when `ds_sel` is 1 and /1 when it is 0. `ds_a_o` and `ds_b_o` are identical in every cycle.
- R3: The feedback ratio is the coarse value (48 if `m1_sel`, else 24) times the fine value (5 if `m2_sel`, else 1), giving 24, 48, 120 or 240.
- R4: `sysref_o` has a period of 48 source cycles under every select setting.
- R5: `ref_to_pd` equals `ref_in1` when `ref_pick` is 1 and `ref_in0` when it is 0, in the same cycle with no register.
- R6: Every output is high for between 47% and 53% of its period, measured in half-cycles. This includes /1 and /3.
- R7: With `m2_sel` low, every half-cycle in which the feedback output rises is also a rising half-cycle of the upstream and downstream outputs.
- R8: While `rst` is high, all phases are zero. The pairs then show their first-cycle values: a /1 output shows 2'b10, and any ratio of 2 or more shows 2'b11.
- R9: A select change takes effect only at the next 240-cycle epoch. Across the change, no high or low run of an output is shorter than the smaller of its old and new half-periods.
- R10: With every select pin low, which is the level an unconnected pin settles to, the ratios are /1 upstream, /1 downstream and /24 feedback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-rate source clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in0 | input | 1 | Reference candidate 0 |
| ref_in1 | input | 1 | Reference candidate 1 |
| ref_pick | input | 1 | 1 routes ref_in1, 0 routes ref_in0 |
| ds_sel | input | 1 | Downstream ratio select |
| us_sel | input | 2 | Upstream ratio select |
| m1_sel | input | 1 | Coarse feedback stage select |
| m2_sel | input | 1 | Fine (/5) feedback stage select |
| ref_to_pd | output | 1 | Chosen reference to phase comparison |
| ds_a_o | output | 2 | Downstream clock, half-cycle pair |
| ds_b_o | output | 2 | Downstream clock copy, half-cycle pair |
| us_o | output | 2 | Upstream clock, half-cycle pair |
| sysref_o | output | 2 | System reference (source/48), half-cycle pair |
| fb_o | output | 2 | Feedback clock, half-cycle pair |

## Verification
The assertions assume that the select pins are static between deliberate changes and that reset lasts for at least one clock edge. Under those conditions every phase counter stays below its modulus, and all counters reach their last phase on the epoch's terminal cycle. The bench changes selects only on whole clock cycles and waits well beyond one epoch before it measures. It also watches an output continuously across a deliberate ratio change, so the epoch hand-over is checked as well as the settled ratios.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;

  typedef struct packed {
    logic       ds;
    logic [1:0] us;
    logic       m1;
    logic       m2;
  } div_sel_t;

  // Level pair for one source cycle: [1] first half, [0] second half.
  // High while the half-cycle index is below the ratio.
  function automatic logic [1:0] half_wave(input int unsigned ph, input int unsigned n);
    return {(2 * ph) < n, (2 * ph + 1) < n};
  endfunction

  function automatic int unsigned us_ratio(input logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 3;
      2'd2:    return 6;
      default: return 12;
    endcase
  endfunction

endpackage

// File: rtl/clkdiv_phase_ctr.sv
`timescale 1ns/1ps
module clkdiv_phase_ctr #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          adv,
  input  logic [CW-1:0] modulus,
  output logic [CW-1:0] cnt,
  output logic          wrap
);
  logic at_last;
  assign at_last = (cnt == modulus - CW'(1));
  assign wrap    = adv && at_last;

  always_ff @(posedge clk) begin
    if (rst || restart)  cnt <= '0;
    else if (wrap)       cnt <= '0;
    else if (adv)        cnt <= cnt + CW'(1);
  end

  a_r1_phase_in_range: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (cnt < modulus));
endmodule

// File: rtl/clkdiv_sel_sync.sv
`timescale 1ns/1ps
module clkdiv_sel_sync
  import clkdiv_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     load,
  input  div_sel_t pins,
  output div_sel_t act
);
  div_sel_t pins_q;

  always_ff @(posedge clk) begin
    pins_q <= pins;
    if (rst)       act <= pins;
    else if (load) act <= pins_q;
  end

  a_r9_hold_between_epochs: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load)) |-> $stable(act));
endmodule

// File: rtl/clkdiv_bank.sv
`timescale 1ns/1ps
module clkdiv_bank
  import clkdiv_pkg::*;
#(
  parameter int EPOCH      = 240,
  parameter int M1_LO      = 24,
  parameter int M1_HI      = 48,
  parameter int M2_HI      = 5,
  parameter int SYSREF_DIV = 48
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_in0,
  input  logic       ref_in1,
  input  logic       ref_pick,
  input  logic       ds_sel,
  input  logic [1:0] us_sel,
  input  logic       m1_sel,
  input  logic       m2_sel,
  output logic       ref_to_pd,
  output logic [1:0] ds_a_o,
  output logic [1:0] ds_b_o,
  output logic [1:0] us_o,
  output logic [1:0] sysref_o,
  output logic [1:0] fb_o
);
  localparam int CW     = $clog2(EPOCH + 1);
  localparam int NFREE  = 3;   // 0 upstream, 1 downstream, 2 coarse feedback
  localparam int REF_LO = SYSREF_DIV / M1_LO;
  localparam int REF_HI = SYSREF_DIV / M1_HI;

  // Straight reference routing
  assign ref_to_pd = ref_pick ? ref_in1 : ref_in0;

  // Epoch counter: the common alignment point
  logic [CW-1:0] ep_cnt;
  logic          epoch_term;
  clkdiv_phase_ctr #(.CW(CW)) u_epoch (
    .clk(clk), .rst(rst), .restart(1'b0), .adv(1'b1),
    .modulus(CW'(EPOCH)), .cnt(ep_cnt), .wrap(epoch_term));

  // Selects, taken in only at the epoch
  div_sel_t pins, act;
  assign pins = {ds_sel, us_sel, m1_sel, m2_sel};
  clkdiv_sel_sync u_sel (
    .clk(clk), .rst(rst), .load(epoch_term), .pins(pins), .act(act));

  // Free-running dividers
  logic [CW-1:0]    free_mod  [NFREE];
  logic [CW-1:0]    free_cnt  [NFREE];
  logic [NFREE-1:0] free_wrap;
  assign free_mod[0] = CW'(us_ratio(act.us));
  assign free_mod[1] = act.ds ? CW'(2) : CW'(1);
  assign free_mod[2] = act.m1 ? CW'(M1_HI) : CW'(M1_LO);

  for (genvar g = 0; g < NFREE; g++) begin : g_free
    clkdiv_phase_ctr #(.CW(CW)) u_ctr (
      .clk(clk), .rst(rst), .restart(epoch_term), .adv(1'b1),
      .modulus(free_mod[g]), .cnt(free_cnt[g]), .wrap(free_wrap[g]));
  end

  // Stages stepped by the coarse wrap: fine feedback and reference divider
  logic          m1_wrap;
  logic [CW-1:0] m2_mod, m2_cnt, rt_mod, rt_cnt;
  logic          m2_wrap, rt_wrap;
  assign m1_wrap = free_wrap[2];
  assign m2_mod  = act.m2 ? CW'(M2_HI) : CW'(1);
  assign rt_mod  = act.m1 ? CW'(REF_HI) : CW'(REF_LO);

  clkdiv_phase_ctr #(.CW(CW)) u_m2 (
    .clk(clk), .rst(rst), .restart(epoch_term), .adv(m1_wrap),
    .modulus(m2_mod), .cnt(m2_cnt), .wrap(m2_wrap));
  clkdiv_phase_ctr #(.CW(CW)) u_rt (
    .clk(clk), .rst(rst), .restart(epoch_term), .adv(m1_wrap),
    .modulus(rt_mod), .cnt(rt_cnt), .wrap(rt_wrap));

  // Output waveform generation
  int unsigned fb_ph, fb_n, sr_ph;
  always_comb begin
    fb_ph = int'(m2_cnt) * int'(free_mod[2]) + int'(free_cnt[2]);
    fb_n  = int'(m2_mod) * int'(free_mod[2]);
    sr_ph = int'(rt_cnt) * int'(free_mod[2]) + int'(free_cnt[2]);
  end

  assign us_o     = half_wave(int'(free_cnt[0]), int'(free_mod[0]));
  assign ds_a_o   = half_wave(int'(free_cnt[1]), int'(free_mod[1]));
  assign ds_b_o   = ds_a_o;
  assign fb_o     = half_wave(fb_ph, fb_n);
  assign sysref_o = half_wave(sr_ph, SYSREF_DIV);

  // Named events for the checks
  logic fb_start;
  assign fb_start = (free_cnt[2] == '0) && (m2_cnt == '0);

  a_r7_epoch_all_wrap: assert property (@(posedge clk) disable iff (rst)
    epoch_term |-> ((&free_wrap) && (m2_cnt == m2_mod - CW'(1)) && (rt_cnt == rt_mod - CW'(1))));

  a_r7_fb_start_aligned: assert property (@(posedge clk) disable iff (rst)
    (fb_start && !act.m2) |-> (free_cnt[0] == '0 && free_cnt[1] == '0));

  a_r3_fine_steps_on_coarse_wrap: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (m2_cnt != $past(m2_cnt))) |-> $past(m1_wrap || epoch_term));

  a_r4_refdiv_steps_on_coarse_wrap: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (rt_cnt != $past(rt_cnt))) |-> $past(m1_wrap || epoch_term));
endmodule

// File: tb/clkdiv_bank_test.sv
`timescale 1ns/1ps
module clkdiv_bank_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_in0 = 1'b0, ref_in1 = 1'b0, ref_pick = 1'b0;
  logic ds_sel = 1'b0, m1_sel = 1'b0, m2_sel = 1'b0;
  logic [1:0] us_sel = 2'b00;
  logic ref_to_pd;
  logic [1:0] ds_a_o, ds_b_o, us_o, sysref_o, fb_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  clkdiv_bank uut (
    .clk(clk), .rst(rst), .ref_in0(ref_in0), .ref_in1(ref_in1), .ref_pick(ref_pick),
    .ds_sel(ds_sel), .us_sel(us_sel), .m1_sel(m1_sel), .m2_sel(m2_sel),
    .ref_to_pd(ref_to_pd), .ds_a_o(ds_a_o), .ds_b_o(ds_b_o), .us_o(us_o),
    .sysref_o(sysref_o), .fb_o(fb_o));

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", rq, what, act, expv);
    end
  endtask

  function automatic logic [1:0] probe(input int w);
    case (w)
      0:       return us_o;
      1:       return ds_a_o;
      2:       return fb_o;
      default: return sysref_o;
    endcase
  endfunction

  function automatic int exp_us(input logic [1:0] c);
    if (c == 2'b11) return 12;
    if (c == 2'b10) return 6;
    if (c == 2'b01) return 3;
    return 1;
  endfunction

  // Period and high time in half-cycles between two rising edges
  task automatic measure(input int w, input int n, input string rq, input string name);
    int per = 0, hi = 0, prev = 1;
    bit started = 0, done = 0;
    for (int c = 0; c < 2 * n + 4 && !done; c++) begin
      @(negedge clk);
      for (int k = 0; k < 2 && !done; k++) begin
        int lvl = (k == 0) ? int'(probe(w)[1]) : int'(probe(w)[0]);
        if (prev == 0 && lvl == 1) begin
          if (started) done = 1;
          else begin started = 1; per = 0; hi = 0; end
        end
        if (started && !done) begin per++; if (lvl == 1) hi++; end
        prev = lvl;
      end
    end
    chk(done && per == 2 * n, rq, {name, " period halves"}, per, 2 * n);
    chk(done && hi * 100 >= 47 * per && hi * 100 <= 53 * per, "R6",
        {name, " high halves"}, hi, n);
  endtask

  task automatic t_reset;
    rst = 1'b1; ds_sel = 0; us_sel = 0; m1_sel = 0; m2_sel = 0;
    repeat (3) @(negedge clk);
    chk(us_o == 2'b10, "R8", "us pair in reset", us_o, 2);
    chk(ds_a_o == 2'b10, "R8", "ds pair in reset", ds_a_o, 2);
    chk(fb_o == 2'b11, "R8", "fb pair in reset", fb_o, 3);
    chk(sysref_o == 2'b11, "R8", "sysref pair in reset", sysref_o, 3);
    @(posedge clk); #1 rst = 1'b0;
    measure(0, 1, "R10", "us default");
    measure(1, 1, "R10", "ds default");
    measure(2, 24, "R10", "fb default");
  endtask

  task automatic t_align(input int n);
    int bad = 0, seen = 0;
    logic [1:0] pf = 2'b11, pu = 2'b11, pd = 2'b11;
    for (int c = 0; c < 2 * n + 4; c++) begin
      @(negedge clk);
      if (pf[0] == 0 && fb_o[1] == 1) begin
        seen++;
        if (!(pu[0] == 0 && us_o[1] == 1)) bad++;
        if (!(pd[0] == 0 && ds_a_o[1] == 1)) bad++;
      end
      pf = fb_o; pu = us_o; pd = ds_a_o;
    end
    chk(bad == 0 && seen > 0, "R7", "misaligned rising edges", bad, 0);
  endtask

  task automatic t_config(input logic d, input logic [1:0] u, input logic a, input logic b);
    int bad = 0;
    @(posedge clk); #1 ds_sel = d; us_sel = u; m1_sel = a; m2_sel = b;
    repeat (300) @(posedge clk);
    measure(0, exp_us(u), "R1", "us");
    measure(1, d ? 2 : 1, "R2", "ds");
    measure(2, (a ? 48 : 24) * (b ? 5 : 1), "R3", "fb");
    measure(3, 48, "R4", "sysref");
    for (int c = 0; c < 50; c++) begin
      @(negedge clk);
      if (ds_a_o != ds_b_o) bad++;
    end
    chk(bad == 0, "R2", "ds copies differ", bad, 0);
    if (!b) t_align(a ? 48 : 24);
  endtask

  task automatic t_refpick;
    @(posedge clk); #1 ref_in0 = 1; ref_in1 = 0; ref_pick = 0;
    @(negedge clk); chk(ref_to_pd == 1'b1, "R5", "pick 0 routes in0", ref_to_pd, 1);
    #1 ref_pick = 1;
    #0.5 chk(ref_to_pd == 1'b0, "R5", "pick 1 routes in1", ref_to_pd, 0);
    #1 ref_in0 = 0; ref_in1 = 1;
    #0.5 chk(ref_to_pd == 1'b1, "R5", "in1 follows", ref_to_pd, 1);
    #1 ref_pick = 0;
    #0.5 chk(ref_to_pd == 1'b0, "R5", "back to in0", ref_to_pd, 0);
  endtask

  task automatic t_runt;
    int run = 0, minrun = 1000, prev = -1, runs = 0;
    @(posedge clk); #1 us_sel = 2'b11; ds_sel = 0; m1_sel = 0; m2_sel = 0;
    repeat (300) @(posedge clk);
    #1 us_sel = 2'b01;
    for (int c = 0; c < 600; c++) begin
      @(negedge clk);
      for (int k = 0; k < 2; k++) begin
        int lvl = (k == 0) ? int'(us_o[1]) : int'(us_o[0]);
        if (lvl == prev) run++;
        else begin
          if (runs > 0 && run < minrun) minrun = run;
          if (prev >= 0) runs++;
          run = 1;
        end
        prev = lvl;
      end
    end
    chk(minrun >= 3, "R9", "shortest run across change", minrun, 3);
    measure(0, 3, "R9", "us after change");
  endtask

  initial begin
    #(4 * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    t_reset();
    t_config(1'b0, 2'b00, 1'b0, 1'b0);
    t_config(1'b1, 2'b01, 1'b1, 1'b0);
    t_config(1'b0, 2'b10, 1'b0, 1'b1);
    t_config(1'b1, 2'b11, 1'b1, 1'b1);
    t_config(1'b1, 2'b01, 1'b0, 1'b0);
    t_refpick();
    t_runt();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule